// File: doc/BRIEF.md
# Speculative Branch History with Per-Branch Checkpoints

This block keeps the global branch history for a front end in two registers. The speculative history is what the direction predictor reads. Each accepted prediction shifts its predicted direction into this copy straight away, so branches that follow one another never look up with the same stale history. The retirement history advances only when a branch commits, and it uses the actual direction.

When a prediction is accepted, the speculative history as it stood just before that prediction is saved in a checkpoint slot, selected by the branch's ID. If execution later finds that the branch went the other way, it reports the ID and the actual direction. The speculative history is then rebuilt from that slot with the actual direction appended, without waiting for the branch to retire. A flush raised at commit time copies the retirement history into the speculative copy.

The predict port is a valid/ready stream. `pred_ready` drops in any cycle in which a mispredict or a flush is presented. A prediction offered in such a cycle is not taken and must be held until `pred_ready` is high. The mispredict, commit and flush inputs are plain pulses that always take effect.

Top module: `spec_hist_ckpt`

## Requirements
- R1: After reset, `spec_hist`, `ret_hist` and every checkpoint slot are all zero.
- R2: A prediction is accepted when `pred_valid` and `pred_ready` are both high. Acceptance shifts `spec_hist` left by one, with `pred_taken` (1 = taken) entering bit 0, and the result is visible the cycle after the accepting edge. The oldest bit (bit HIST_W-1) is dropped.
- R3: An accepted prediction stores the pre-shift `spec_hist` into slot `pred_id`. A slot that is not written keeps its contents.
- R4: A mispredict with `misp_valid` high (and no flush) sets `spec_hist` to slot `misp_id` shifted left by one, with `misp_taken` in bit 0, on the next edge.
- R5: `pred_ready` is low in every cycle in which `misp_valid` or `flush` is high, and high otherwise. A prediction offered in such a cycle leaves neither `spec_hist` nor any checkpoint slot changed.
- R6: `commit_valid` shifts `commit_taken` into bit 0 of `ret_hist` on the next edge. Without `commit_valid`, `ret_hist` holds its value.
- R7: `flush` loads `spec_hist` with the retirement history, including any commit presented in the same cycle. It overrides a simultaneous mispredict.
- R8: With no accepted prediction, no mispredict and no flush, `spec_hist` holds its value.
- R9: Slots 0 and NUM_IDS-1 are stored and restored like any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A prediction is offered |
| pred_ready | output | 1 | The prediction is accepted this cycle |
| pred_id | input | ID_W | Branch ID of the predicted branch |
| pred_taken | input | 1 | Predicted direction, 1 = taken |
| misp_valid | input | 1 | Execution reports a mispredicted branch |
| misp_id | input | ID_W | Branch ID of the mispredicted branch |
| misp_taken | input | 1 | Actual direction of that branch |
| commit_valid | input | 1 | A branch commits |
| commit_taken | input | 1 | Actual direction of the committing branch |
| flush | input | 1 | Copy the retirement history into the speculative history |
| spec_hist | output | HIST_W | Speculative history, newest bit at bit 0 |
| ret_hist | output | HIST_W | Retirement history, newest bit at bit 0 |

## Verification
The bench builds the block with its default parameters: a 12-bit history and 16 slots addressed by a 4-bit ID. With these values, a run of more than twelve predictions pushes the oldest bits out of the history. The two end slots, 0 and 15, can both be written and then restored. Collisions are driven deliberately: a prediction offered alongside a mispredict, a flush offered alongside a mispredict, and a flush offered alongside a commit. Each of these collisions checks the stated priority and the back-pressure rule.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [1:0] {
    SPEC_HOLD    = 2'd0,
    SPEC_SHIFT   = 2'd1,
    SPEC_RESTORE = 2'd2,
    SPEC_RELOAD  = 2'd3
  } spec_src_e;
endpackage

// File: rtl/bhr_ckpt_store.sv
module bhr_ckpt_store #(
  parameter int HIST_W  = 12,
  parameter int NUM_IDS = 16,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [HIST_W-1:0] wr_data,
  input  logic [ID_W-1:0]   rd_id,
  output logic [HIST_W-1:0] rd_data
);
  logic [HIST_W-1:0] slot_q [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic [HIST_W-1:0] snap_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  snap_q <= '0;
      else if (wr_en && wr_id == ID_W'(g))         snap_q <= wr_data;
    end
    assign slot_q[g] = snap_q;
  end

  assign rd_data = slot_q[rd_id];
endmodule

// File: rtl/bhr_spec_ctrl.sv
module bhr_spec_ctrl
  import bhr_pkg::*;
(
  input  logic      pred_valid,
  input  logic      misp_valid,
  input  logic      flush,
  output logic      pred_ready,
  output logic      pred_fire,
  output spec_src_e spec_src
);
  always_comb begin
    pred_ready = !(misp_valid || flush);
    pred_fire  = pred_valid && pred_ready;
    if (flush)          spec_src = SPEC_RELOAD;
    else if (misp_valid) spec_src = SPEC_RESTORE;
    else if (pred_fire)  spec_src = SPEC_SHIFT;
    else                 spec_src = SPEC_HOLD;
  end
endmodule

// File: rtl/bhr_hist_reg.sv
module bhr_hist_reg
  import bhr_pkg::*;
#(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spec_src_e         src,
  input  logic              shift_bit,
  input  logic [HIST_W-1:0] restore_base,
  input  logic              restore_bit,
  input  logic [HIST_W-1:0] reload_val,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    unique case (src)
      SPEC_SHIFT:   hist_d = {hist_q[HIST_W-2:0], shift_bit};
      SPEC_RESTORE: hist_d = {restore_base[HIST_W-2:0], restore_bit};
      SPEC_RELOAD:  hist_d = reload_val;
      default:      hist_d = hist_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/bhr_ret_reg.sv
module bhr_ret_reg #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_valid,
  input  logic              commit_taken,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] hist_d
);
  assign hist_d = commit_valid ? {hist_q[HIST_W-2:0], commit_taken} : hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/spec_hist_ckpt.sv
module spec_hist_ckpt
  import bhr_pkg::*;
#(
  parameter int HIST_W  = 12,
  parameter int NUM_IDS = 16,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [ID_W-1:0]   pred_id,
  input  logic              pred_taken,
  input  logic              misp_valid,
  input  logic [ID_W-1:0]   misp_id,
  input  logic              misp_taken,
  input  logic              commit_valid,
  input  logic              commit_taken,
  input  logic              flush,
  output logic [HIST_W-1:0] spec_hist,
  output logic [HIST_W-1:0] ret_hist
);
  logic              pred_fire;
  spec_src_e         spec_src;
  logic [HIST_W-1:0] ckpt_rd;
  logic [HIST_W-1:0] ret_next;

  bhr_spec_ctrl u_ctrl (
    .pred_valid (pred_valid),
    .misp_valid (misp_valid),
    .flush      (flush),
    .pred_ready (pred_ready),
    .pred_fire  (pred_fire),
    .spec_src   (spec_src)
  );

  bhr_ckpt_store #(.HIST_W(HIST_W), .NUM_IDS(NUM_IDS)) u_ckpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pred_fire),
    .wr_id   (pred_id),
    .wr_data (spec_hist),
    .rd_id   (misp_id),
    .rd_data (ckpt_rd)
  );

  bhr_ret_reg #(.HIST_W(HIST_W)) u_ret (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_valid (commit_valid),
    .commit_taken (commit_taken),
    .hist_q       (ret_hist),
    .hist_d       (ret_next)
  );

  bhr_hist_reg #(.HIST_W(HIST_W)) u_spec (
    .clk          (clk),
    .rst_n        (rst_n),
    .src          (spec_src),
    .shift_bit    (pred_taken),
    .restore_base (ckpt_rd),
    .restore_bit  (misp_taken),
    .reload_val   (ret_next),
    .hist_q       (spec_hist)
  );
endmodule

// File: rtl/spec_hist_ckpt_chk.sv
module spec_hist_ckpt_chk #(
  parameter int HIST_W = 12,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic              pred_taken,
  input logic              misp_valid,
  input logic              misp_taken,
  input logic              commit_valid,
  input logic              commit_taken,
  input logic              flush,
  input logic [HIST_W-1:0] spec_hist,
  input logic [HIST_W-1:0] ret_hist
);
  assert_pred_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready) |=> spec_hist == {$past(spec_hist[HIST_W-2:0]), $past(pred_taken)});

  assert_restore_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (misp_valid && !flush) |=> spec_hist[0] == $past(misp_taken));

  assert_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (misp_valid || flush) |-> !pred_ready);

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(misp_valid || flush) |-> pred_ready);

  assert_commit_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> ret_hist == {$past(ret_hist[HIST_W-2:0]), $past(commit_taken)});

  assert_ret_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |=> $stable(ret_hist));

  assert_flush_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spec_hist == ret_hist);

  assert_spec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pred_valid && pred_ready) && !misp_valid && !flush |=> $stable(spec_hist));
endmodule

bind spec_hist_ckpt spec_hist_ckpt_chk #(.HIST_W(HIST_W), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_valid   (pred_valid),
  .pred_ready   (pred_ready),
  .pred_taken   (pred_taken),
  .misp_valid   (misp_valid),
  .misp_taken   (misp_taken),
  .commit_valid (commit_valid),
  .commit_taken (commit_taken),
  .flush        (flush),
  .spec_hist    (spec_hist),
  .ret_hist     (ret_hist)
);

// File: tb/tb_spec_hist_ckpt.sv
module tb_spec_hist_ckpt;
  localparam int W = 12;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 0, pred_taken = 0, misp_valid = 0, misp_taken = 0;
  logic commit_valid = 0, commit_taken = 0, flush = 0;
  logic [IW-1:0] pred_id = '0, misp_id = '0;
  logic pred_ready;
  logic [W-1:0] spec_hist, ret_hist;

  int checks = 0;
  int fails = 0;

  logic [W-1:0] m_spec = '0, m_ret = '0;
  logic [W-1:0] m_ck [N];
  logic [2*W-1:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  spec_hist_ckpt dut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_id(pred_id), .pred_taken(pred_taken), .misp_valid(misp_valid),
    .misp_id(misp_id), .misp_taken(misp_taken), .commit_valid(commit_valid),
    .commit_taken(commit_taken), .flush(flush), .spec_hist(spec_hist), .ret_hist(ret_hist)
  );

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: one pushed item is due just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      automatic logic [2*W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, {spec_hist, ret_hist}, e);
    end
  end

  // Driver: applies one cycle of stimulus and pushes the model's result.
  task automatic step(input string req,
                      input logic pv, input logic [IW-1:0] pid, input logic pt,
                      input logic mv, input logic [IW-1:0] mid, input logic mt,
                      input logic cv, input logic ct, input logic fl);
    logic [W-1:0] ret_n, spec_n;
    @(negedge clk);
    pred_valid = pv; pred_id = pid; pred_taken = pt;
    misp_valid = mv; misp_id = mid; misp_taken = mt;
    commit_valid = cv; commit_taken = ct; flush = fl;
    #1;
    check({req, " R5 ready"}, {{(2*W-1){1'b0}}, pred_ready}, {{(2*W-1){1'b0}}, !(mv || fl)});
    ret_n = cv ? {m_ret[W-2:0], ct} : m_ret;
    if (fl)      spec_n = ret_n;
    else if (mv) spec_n = {m_ck[mid][W-2:0], mt};
    else if (pv) begin
      m_ck[pid] = m_spec;
      spec_n = {m_spec[W-2:0], pt};
    end else     spec_n = m_spec;
    m_spec = spec_n;
    m_ret = ret_n;
    exp_q.push_back({spec_n, ret_n});
    tag_q.push_back(req);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_ck[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2 check("R1 reset", {spec_hist, ret_hist}, '0);
    // R1: untouched slot restores to zero plus the actual bit
    step("R1 slot zero", 0, 0, 0, 1, 4'd7, 1, 0, 0, 0);
    idle("R8 hold");
    // R2/R3: predict pattern
    step("R2 shift T", 1, 4'd1, 1, 0, 0, 0, 0, 0, 0);
    step("R2 shift N", 1, 4'd2, 0, 0, 0, 0, 0, 0, 0);
    step("R2 shift T", 1, 4'd3, 1, 0, 0, 0, 0, 0, 0);
    step("R2 shift T", 1, 4'd4, 1, 0, 0, 0, 0, 0, 0);
    idle("R8 hold");
    // R4: restore from slot 3 with flipped outcome
    step("R4 restore id3", 0, 0, 0, 1, 4'd3, 0, 0, 0, 0);
    // R5: prediction with a mispredict: restore wins, slot 9 untouched
    step("R5 collide", 1, 4'd9, 1, 1, 4'd2, 1, 0, 0, 0);
    step("R5 slot9 unchanged", 0, 0, 0, 1, 4'd9, 0, 0, 0, 0);
    // R2: wrap past 12 bits
    for (int i = 0; i < 15; i++)
      step("R2 wrap", 1, IW'(i % 8 + 5), (i % 3) != 0, 0, 0, 0, 0, 0, 0);
    // R9: end slots
    step("R9 write id0", 1, 4'd0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 write id15", 1, 4'd15, 1, 0, 0, 0, 0, 0, 0);
    step("R9 more", 1, 4'd6, 1, 0, 0, 0, 0, 0, 0);
    step("R9 restore id15", 0, 0, 0, 1, 4'd15, 0, 0, 0, 0);
    step("R9 restore id0", 0, 0, 0, 1, 4'd0, 1, 0, 0, 0);
    // R6: commits
    step("R6 commit T", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    step("R6 commit N", 1, 4'd8, 1, 0, 0, 0, 1, 0, 0);
    step("R6 commit T", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    idle("R6 hold");
    // R7: flush with same-cycle commit, and over a mispredict and predict
    step("R7 flush+commit", 1, 4'd10, 0, 1, 4'd4, 1, 1, 1, 1);
    step("R7 predict after", 1, 4'd11, 1, 0, 0, 0, 0, 0, 0);
    step("R7 flush plain", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R8 hold");
    idle("R8 drain");
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule